// File: doc/BRIEF.md
# Memory-Mapped Port Controller with Atomic Bit Updates

This block controls one port of up to 32 general-purpose pins through a small synchronous register bus. Software writes an output-data register and a direction register. Three further write-only locations let a single bus write raise, lower or flip chosen output bits. No read-modify-write is needed, so code on another bus master cannot lose an update made to other bits of the same port.

On the input side, raw pin levels pass through a two-stage synchronizer before they are captured in an input-data register. A pin that is not configured for a digital function reads as 0. While the port module is disabled, the captured value holds. A parameter mask states which pins exist on the port. Missing pins read 0 and never have their output driver enabled.

Every bus access takes one cycle and nothing stalls it, so the bus has no valid/ready handshake. Read data is returned registered, one cycle after the read strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output-data and direction registers and the captured input are 0, pin_out and pin_oe are all 0, and bus_rdata is 0.
- R2: A write to byte offset 0x00 loads all 32 bits of the output-data register, which drives pin_out from the next cycle. The same offset reads it back in full. When no write is made, pin_out does not change.
- R3: A write to offset 0x04 sets to 1 every output-data bit whose written bit is 1, and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears to 0 every output-data bit whose written bit is 1, and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every output-data bit whose written bit is 1, and leaves the other bits unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C always return 0.
- R7: Offset 0x14 holds the direction register, read/write over all 32 bits. A bit of 1 makes the pin an output, so pin_oe equals the direction register ANDed with the implemented-pin mask.
- R8: Offset 0x10 reads the captured input. A pin level changed just before a clock edge is not visible to a read strobed on the second edge after it, and is visible to a read strobed on the third edge.
- R9: A captured input bit is 0 wherever pin_dig_en is 0 at the capture edge.
- R10: While port_en is 0, the captured input holds its last value whatever the pins do. It follows the pins again once port_en returns to 1.
- R11: Bits outside the parameter IMPL_MASK (default 0xFFFFF0FF) read 0 at offset 0x10 and have pin_oe held at 0.
- R12: Writes to offset 0x10, to unmapped offsets or to offsets not aligned to 4 bytes change no register.
- R13: bus_rdata carries the selected register in the cycle after bus_rd is high and is 0 in the cycle after bus_rd is low. A read and a write in the same cycle return the value before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH (32) | Registered read data |
| pin_in | input | WIDTH (32) | Raw pin levels, asynchronous |
| pin_dig_en | input | WIDTH (32) | Per-pin digital-function enable |
| port_en | input | 1 | Port module enable; 0 freezes the captured input |
| pin_out | output | WIDTH (32) | Output level per pin |
| pin_oe | output | WIDTH (32) | Output-driver enable per pin |

## Verification
The hardest situations to reach from the ports are the frozen input and the exact edge at which a pin change becomes visible. In both, the captured value cannot be observed directly and has to be reached through timed reads. The bench first captures a known pattern and then drops port_en. It changes the pins and digital enables while the port is disabled, and then reads back the old pattern. To check the latency, it changes the pins at a known falling edge and issues one read that is one edge too early and one that is just in time. Random mixes of set, clear, toggle and full writes run against a bench model to exercise the atomic paths on overlapping masks.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Byte offsets: software depends on these, so they are fixed
  localparam int OFS_DATA = 'h00;
  localparam int OFS_SET  = 'h04;
  localparam int OFS_CLR  = 'h08;
  localparam int OFS_TOG  = 'h0C;
  localparam int OFS_IN   = 'h10;
  localparam int OFS_DIR  = 'h14;

  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_SET  = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_TOG  = 3'd3,
    SEL_IN   = 3'd4,
    SEL_DIR  = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_DATA))     sel = SEL_DATA;
    else if (addr == ADDR_W'(OFS_SET)) sel = SEL_SET;
    else if (addr == ADDR_W'(OFS_CLR)) sel = SEL_CLR;
    else if (addr == ADDR_W'(OFS_TOG)) sel = SEL_TOG;
    else if (addr == ADDR_W'(OFS_IN))  sel = SEL_IN;
    else if (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
    else                               sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_outregs.sv
module gpio_port_outregs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DATA: out_q <= wdata;
        SEL_SET:  out_q <= out_q | wdata;
        SEL_CLR:  out_q <= out_q & ~wdata;
        SEL_TOG:  out_q <= out_q ^ wdata;
        SEL_DIR:  dir_q <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_inreg.sv
module gpio_port_inreg #(
  parameter int               WIDTH     = 32,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] dig_en,
  output logic [WIDTH-1:0] in_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       in_q <= '0;
    else if (port_en) in_q <= pin_sync & dig_en & IMPL_MASK;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH       = 32,
  parameter int               ADDR_W      = 5,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] IMPL_MASK   = 32'hFFFF_F0FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  pin_dig_en,
  input  logic              port_en,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] out_q, dir_q, in_q, pin_sync, rd_mux, rdata_q;

  gpio_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  gpio_port_outregs #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel),
    .wdata(bus_wdata), .out_q(out_q), .dir_q(dir_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_port_inreg #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_in (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .pin_sync(pin_sync), .dig_en(pin_dig_en), .in_q(in_q)
  );

  always_comb begin
    case (sel)
      SEL_DATA: rd_mux = out_q;
      SEL_DIR:  rd_mux = dir_q;
      SEL_IN:   rd_mux = in_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q & IMPL_MASK;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH     = 32,
  parameter int               ADDR_W    = 5,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe
);
  logic is_set, is_clr, is_tog, is_data, is_in;
  assign is_set  = bus_addr == ADDR_W'(OFS_SET);
  assign is_clr  = bus_addr == ADDR_W'(OFS_CLR);
  assign is_tog  = bus_addr == ADDR_W'(OFS_TOG);
  assign is_data = bus_addr == ADDR_W'(OFS_DATA);
  assign is_in   = bus_addr == ADDR_W'(OFS_IN);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_data) |=> pin_out == $past(bus_wdata));
  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_set) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));
  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_clr) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));
  assert_tog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_tog) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));
  assert_wo_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (is_set || is_clr || is_tog)) |=> bus_rdata == '0);
  assert_in_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_in) |=> (bus_rdata & ~IMPL_MASK) == '0);
  assert_oe_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~IMPL_MASK) == '0);
  assert_idle_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int          CLK_PERIOD = 10;
  localparam int          W          = 32;
  localparam int          AW         = 5;
  localparam logic [31:0] MASK       = 32'hFFFF_F0FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, port_en = 1'b1;
  logic [W-1:0]  bus_wdata = '0, pin_in = '0, pin_dig_en = '1;
  logic [W-1:0]  bus_rdata, pin_out, pin_oe;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_out = '0, m_dir = '0, m_in = '0;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_dig_en(pin_dig_en), .port_en(port_en),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] f_set(logic [31:0] o, logic [31:0] w); return o | w;  endfunction
  function automatic logic [31:0] f_clr(logic [31:0] o, logic [31:0] w); return o & ~w; endfunction
  function automatic logic [31:0] f_tog(logic [31:0] o, logic [31:0] w); return o ^ w;  endfunction
  function automatic logic [31:0] f_in(logic [31:0] p, logic [31:0] d); return p & d & MASK; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, p_old, p_new;
    void'($urandom(32'd1234));
    idle(3);
    // R1: reset state
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    idle(1);
    bus_read(5'h00, r); check("R1 data reg", r, 32'h0);
    bus_read(5'h14, r); check("R1 dir reg", r, 32'h0);
    bus_read(5'h10, r); check("R1 input reg", r, 32'h0);

    // R2 full write and readback
    bus_write(5'h00, 32'hA5A5_3C3C); m_out = 32'hA5A5_3C3C;
    check("R2 pin_out", pin_out, m_out);
    bus_read(5'h00, r); check("R2 readback", r, m_out);
    // R13 idle cycle after read returns zero
    idle(1); check("R13 idle rdata", bus_rdata, 32'h0);

    // R3/R4/R5 directed on overlapping masks
    bus_write(5'h04, 32'hFF00_00FF); m_out = f_set(m_out, 32'hFF00_00FF);
    check("R3 set", pin_out, m_out);
    bus_write(5'h08, 32'h0F0F_0F0F); m_out = f_clr(m_out, 32'h0F0F_0F0F);
    check("R4 clear", pin_out, m_out);
    bus_write(5'h0C, 32'hFFFF_0000); m_out = f_tog(m_out, 32'hFFFF_0000);
    check("R5 toggle", pin_out, m_out);
    bus_write(5'h0C, 32'h0); check("R5 zero toggle", pin_out, m_out);

    // R6 write-only locations read zero
    bus_read(5'h04, r); check("R6 set reads 0", r, 32'h0);
    bus_read(5'h08, r); check("R6 clear reads 0", r, 32'h0);
    bus_read(5'h0C, r); check("R6 toggle reads 0", r, 32'h0);

    // R7 / R11 direction and masked output enable
    bus_write(5'h14, 32'hFFFF_FFFF); m_dir = 32'hFFFF_FFFF;
    bus_read(5'h14, r); check("R7 dir readback", r, m_dir);
    check("R11 oe masked", pin_oe, m_dir & MASK);
    bus_write(5'h14, 32'h1234_5678); m_dir = 32'h1234_5678;
    check("R7 oe", pin_oe, m_dir & MASK);

    // R13 simultaneous read and write returns old value
    bus_addr = 5'h00; bus_wdata = 32'h5555_AAAA; bus_wr = 1'b1; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R13 read before write", bus_rdata, m_out);
    m_out = 32'h5555_AAAA;
    check("R2 write in same cycle", pin_out, m_out);

    // R12 ignored writes
    bus_write(5'h10, 32'hDEAD_BEEF);
    bus_write(5'h18, 32'hDEAD_BEEF);
    bus_write(5'h01, 32'hDEAD_BEEF);
    bus_write(5'h06, 32'hDEAD_BEEF);
    check("R12 pin_out unchanged", pin_out, m_out);
    bus_read(5'h14, r); check("R12 dir unchanged", r, m_dir);
    bus_read(5'h10, r); check("R12 input unchanged", r, 32'h0);
    bus_read(5'h1C, r); check("R12 unmapped reads 0", r, 32'h0);

    // R11 input mask, R9 digital enable
    pin_in = 32'hFFFF_FFFF; pin_dig_en = 32'hFFFF_FFFF;
    idle(4);
    bus_read(5'h10, r); check("R11 input masked", r, MASK);
    pin_dig_en = 32'h00FF_FF00;
    idle(4);
    bus_read(5'h10, r); check("R9 digital enable", r, f_in(pin_in, pin_dig_en));

    // R8 latency boundary
    pin_dig_en = 32'hFFFF_FFFF;
    p_old = 32'h1111_2222; pin_in = p_old; idle(4);
    p_new = 32'hEEEE_DDDD; pin_in = p_new;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_read(5'h10, r); check("R8 too early", r, f_in(p_old, 32'hFFFF_FFFF));
    bus_read(5'h10, r); check("R8 visible", r, f_in(p_new, 32'hFFFF_FFFF));

    // R10 freeze while disabled
    m_in = f_in(p_new, 32'hFFFF_FFFF);
    port_en = 1'b0;
    pin_in = 32'h0000_0F0F; pin_dig_en = 32'h0F0F_0F0F;
    idle(5);
    bus_read(5'h10, r); check("R10 frozen", r, m_in);
    pin_in = 32'hCAFE_F00D; idle(3);
    bus_read(5'h10, r); check("R10 still frozen", r, m_in);
    port_en = 1'b1; idle(4);
    bus_read(5'h10, r); check("R10 resumes", r, f_in(32'hCAFE_F00D, pin_dig_en));

    // random mix of output operations
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      int op;
      w  = $urandom;
      op = $urandom_range(0, 5);
      case (op)
        0: begin bus_write(5'h00, w); m_out = w; end
        1: begin bus_write(5'h04, w); m_out = f_set(m_out, w); end
        2: begin bus_write(5'h08, w); m_out = f_clr(m_out, w); end
        3: begin bus_write(5'h0C, w); m_out = f_tog(m_out, w); end
        4: begin bus_write(5'h14, w); m_dir = w; end
        default: begin bus_write(5'h10, w); end
      endcase
      if (op == 1)      check("R3 random set", pin_out, m_out);
      else if (op == 2) check("R4 random clear", pin_out, m_out);
      else if (op == 3) check("R5 random toggle", pin_out, m_out);
      else if (op == 4) check("R7 random oe", pin_oe, m_dir & MASK);
      else if (op == 0) check("R2 random load", pin_out, m_out);
      else              check("R12 random ignored", pin_out, m_out);
      if (i % 8 == 0) begin
        bus_read(5'h00, r); check("R2 random readback", r, m_out);
        bus_read(5'h14, r); check("R7 random dir readback", r, m_dir);
      end
    end

    // random input patterns
    for (int i = 0; i < 40; i++) begin
      pin_in = $urandom; pin_dig_en = $urandom; port_en = 1'b1;
      idle(4);
      bus_read(5'h10, r); check("R9 random input", r, f_in(pin_in, pin_dig_en));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule